// File: doc/BRIEF.md
# Programmable Hysteresis Level Trigger

This block watches a stream of 8-bit samples and raises a one-clock trigger pulse when a sample rises above a programmable threshold. A host controller loads the threshold and a hysteresis width through two write strobes that share one data bus. The comparison behaves like a digital Schmitt comparator. After the trigger fires, the block stays disarmed until a sample drops to or below the threshold minus the hysteresis. Noise that hovers around the threshold therefore cannot fire a burst of triggers.

The `armed` output shows whether the next sample above the threshold would fire. Any host write to either register takes effect from the next sample onward and puts the block back into the armed state. Only the rising crossing is detected. There is no holdoff timer.

Top module: `schmitt_level_trig`

## Requirements
- R1: After reset, `armed` is 1, `trig_pulse` is 0, the threshold is RST_LEVEL (default 0x80) and the hysteresis is RST_HYST (default 0x04).
- R2: A cycle with `smp_valid`=1 while armed, no host write, and `smp_data` strictly greater than the threshold makes `trig_pulse` 1 in the next cycle, and `armed` reads 0 from that same cycle on. A sample equal to the threshold does not fire.
- R3: `trig_pulse` is high for exactly one cycle, and only in the cycle after a valid sample. A cycle with `smp_valid`=0 changes neither the armed state nor the pulse, whatever `smp_data` holds.
- R4: While disarmed, valid samples above the lower bound neither fire nor re-arm.
- R5: While disarmed, a valid sample at or below the lower bound (threshold minus hysteresis) sets `armed` to 1 in the next cycle without firing. That same sample cannot also fire.
- R6: If the hysteresis is greater than or equal to the threshold, the lower bound is 0, so only a sample of 0x00 re-arms.
- R7: `cfg_wr_level`=1 loads `cfg_wdata` into the threshold, and `cfg_wr_hyst`=1 loads it into the hysteresis. Both strobes together load both registers. In the cycle after any write, `armed`=1 and `trig_pulse`=0, and a sample presented in the write cycle is ignored.
- R8: With hysteresis 0, a valid sample at or below the threshold re-arms, so every upward crossing of the threshold fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DATA_W | Sample value, unsigned |
| cfg_wr_level | input | 1 | Host write strobe for the threshold |
| cfg_wr_hyst | input | 1 | Host write strobe for the hysteresis |
| cfg_wdata | input | DATA_W | Host write data |
| trig_pulse | output | 1 | One-clock trigger pulse |
| armed | output | 1 | 1 when the next sample above the threshold would fire |

## Verification
The bench targets the following corner cases and the failure each one would expose:
- A sample exactly equal to the threshold must not fire. A design using greater-or-equal would fire on it.
- A sample one step above the lower bound must not re-arm, while a sample exactly at the lower bound must re-arm. An off-by-one error shows up as a missing or early `armed`.
- With the hysteresis larger than the threshold, the lower bound must saturate at 0. A design whose subtraction wraps around would re-arm on large samples and fire repeatedly.
- Host writes are tested in several ways: a write issued in the same cycle as a qualifying sample, a write while disarmed, and a write to both registers at once. A design that lets the sample through or keeps the disarmed state would pulse or stay low.

// File: rtl/trig_pkg.sv
package trig_pkg;

  // Lower re-arm bound: level minus hysteresis, held at zero instead of wrapping.
  function automatic logic [7:0] trig_low_bound(input logic [7:0] level,
                                                input logic [7:0] hyst);
    if (hyst >= level) return 8'd0;
    return level - hyst;
  endfunction

  // Strict rising-side test against the threshold.
  function automatic logic trig_is_above(input logic [7:0] smp,
                                         input logic [7:0] level);
    return smp > level;
  endfunction

endpackage

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs #(
  parameter int              DATA_W    = 8,
  parameter logic [DATA_W-1:0] RST_LEVEL = 8'h80,
  parameter logic [DATA_W-1:0] RST_HYST  = 8'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_level,
  input  logic              wr_hyst,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] level_q,
  output logic [DATA_W-1:0] hyst_q,
  output logic              cfg_hit
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q <= RST_LEVEL;
      hyst_q  <= RST_HYST;
    end else begin
      if (wr_level) level_q <= wdata;
      if (wr_hyst)  hyst_q  <= wdata;
    end
  end

  assign cfg_hit = wr_level | wr_hyst;

endmodule

// File: rtl/trig_compare.sv
module trig_compare #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] smp_data,
  input  logic [DATA_W-1:0] level_q,
  input  logic [DATA_W-1:0] hyst_q,
  output logic [DATA_W-1:0] low_bound,
  output logic              above,
  output logic              below
);
  import trig_pkg::*;

  always_comb begin
    low_bound = trig_low_bound(level_q, hyst_q);
    above     = trig_is_above(smp_data, level_q);
    below     = (smp_data <= low_bound);
  end

endmodule

// File: rtl/trig_fsm.sv
module trig_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_valid,
  input  logic cfg_hit,
  input  logic above,
  input  logic below,
  output logic fire_evt,
  output logic rearm_evt,
  output logic armed,
  output logic trig_pulse
);

  logic sample_ok;

  assign sample_ok = smp_valid & ~cfg_hit;
  assign fire_evt  = armed & sample_ok & above;
  assign rearm_evt = ~armed & sample_ok & below;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed      <= 1'b1;
      trig_pulse <= 1'b0;
    end else begin
      trig_pulse <= fire_evt;
      if (cfg_hit)        armed <= 1'b1;
      else if (fire_evt)  armed <= 1'b0;
      else if (rearm_evt) armed <= 1'b1;
    end
  end

endmodule

// File: rtl/schmitt_level_trig.sv
module schmitt_level_trig #(
  parameter int                DATA_W    = 8,
  parameter logic [DATA_W-1:0] RST_LEVEL = 8'h80,
  parameter logic [DATA_W-1:0] RST_HYST  = 8'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              cfg_wr_level,
  input  logic              cfg_wr_hyst,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              trig_pulse,
  output logic              armed
);

  logic [DATA_W-1:0] level_q;
  logic [DATA_W-1:0] hyst_q;
  logic [DATA_W-1:0] low_bound;
  logic              cfg_hit;
  logic              above;
  logic              below;
  logic              fire_evt;
  logic              rearm_evt;

  trig_cfg_regs #(
    .DATA_W(DATA_W), .RST_LEVEL(RST_LEVEL), .RST_HYST(RST_HYST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_level(cfg_wr_level), .wr_hyst(cfg_wr_hyst), .wdata(cfg_wdata),
    .level_q(level_q), .hyst_q(hyst_q), .cfg_hit(cfg_hit)
  );

  trig_compare #(.DATA_W(DATA_W)) u_cmp (
    .smp_data(smp_data), .level_q(level_q), .hyst_q(hyst_q),
    .low_bound(low_bound), .above(above), .below(below)
  );

  trig_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .cfg_hit(cfg_hit),
    .above(above), .below(below),
    .fire_evt(fire_evt), .rearm_evt(rearm_evt),
    .armed(armed), .trig_pulse(trig_pulse)
  );

endmodule

// File: rtl/trig_checker.sv
module trig_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic [DATA_W-1:0] smp_data,
  input logic              cfg_wr_level,
  input logic              cfg_wr_hyst,
  input logic [DATA_W-1:0] level_q,
  input logic [DATA_W-1:0] hyst_q,
  input logic              trig_pulse,
  input logic              armed
);
  import trig_pkg::*;

  logic wr_any;
  assign wr_any = cfg_wr_level | cfg_wr_hyst;

  AST_PULSE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> $past(smp_valid)); // R3
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |=> !trig_pulse); // R3
  AST_FIRE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> !armed); // R2
  AST_FIRE_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && smp_valid && !wr_any && trig_is_above(smp_data, level_q)) |=> trig_pulse); // R2
  AST_HOLD_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !wr_any && !(smp_valid && smp_data <= trig_low_bound(level_q, hyst_q)))
      |=> (!armed && !trig_pulse)); // R4
  AST_REARM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && smp_valid && !wr_any && smp_data <= trig_low_bound(level_q, hyst_q))
      |=> (armed && !trig_pulse)); // R5
  AST_WRITE_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any |=> (armed && !trig_pulse)); // R7

endmodule

bind schmitt_level_trig trig_checker #(.DATA_W(DATA_W)) u_trig_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
  .cfg_wr_level(cfg_wr_level), .cfg_wr_hyst(cfg_wr_hyst),
  .level_q(level_q), .hyst_q(hyst_q),
  .trig_pulse(trig_pulse), .armed(armed)
);

// File: tb/test_schmitt_level_trig.sv
module test_schmitt_level_trig;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_valid = 1'b0;
  logic [7:0] smp_data = 8'h00;
  logic       cfg_wr_level = 1'b0;
  logic       cfg_wr_hyst = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       trig_pulse;
  logic       armed;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  schmitt_level_trig i_schmitt_level_trig (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .cfg_wr_level(cfg_wr_level), .cfg_wr_hyst(cfg_wr_hyst), .cfg_wdata(cfg_wdata),
    .trig_pulse(trig_pulse), .armed(armed)
  );

  // Vector fields: wr_level, wr_hyst, wdata[7:0], valid, data[7:0], exp_pulse, exp_armed
  localparam int NV = 18;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0,1'b0,8'h00, 1'b1,8'h90, 1'b1,1'b0}, // R2 fire above 0x80
    {1'b0,1'b0,8'h00, 1'b1,8'hA0, 1'b0,1'b0}, // R4 disarmed, high
    {1'b0,1'b0,8'h00, 1'b1,8'h7D, 1'b0,1'b0}, // R4 one above bound 0x7C
    {1'b0,1'b0,8'h00, 1'b1,8'h7C, 1'b0,1'b1}, // R5 at bound re-arms
    {1'b0,1'b0,8'h00, 1'b1,8'h80, 1'b0,1'b1}, // R2 equal does not fire
    {1'b0,1'b0,8'h00, 1'b0,8'hFF, 1'b0,1'b1}, // R3 invalid ignored
    {1'b0,1'b0,8'h00, 1'b1,8'h81, 1'b1,1'b0}, // R2 fire
    {1'b0,1'b0,8'h00, 1'b0,8'h00, 1'b0,1'b0}, // R3 invalid low ignored
    {1'b0,1'b1,8'h00, 1'b1,8'hFF, 1'b0,1'b1}, // R7 hyst=0, sample ignored
    {1'b0,1'b0,8'h00, 1'b1,8'h81, 1'b1,1'b0}, // R8 crossing fires
    {1'b0,1'b0,8'h00, 1'b1,8'h80, 1'b0,1'b1}, // R8 at level re-arms
    {1'b0,1'b0,8'h00, 1'b1,8'h81, 1'b1,1'b0}, // R8 fires again
    {1'b1,1'b0,8'h10, 1'b0,8'h00, 1'b0,1'b1}, // R7 level=0x10 re-arms
    {1'b0,1'b1,8'h20, 1'b0,8'h00, 1'b0,1'b1}, // R7 hyst=0x20
    {1'b0,1'b0,8'h00, 1'b1,8'h11, 1'b1,1'b0}, // R2 fire on new level
    {1'b0,1'b0,8'h00, 1'b1,8'h01, 1'b0,1'b0}, // R6 bound saturated to 0
    {1'b0,1'b0,8'h00, 1'b1,8'h00, 1'b0,1'b1}, // R6 zero re-arms
    {1'b0,1'b0,8'h00, 1'b1,8'hFF, 1'b1,1'b0}  // R2 fire
  };

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic wl, input logic wh, input logic [7:0] wd,
                       input logic v, input logic [7:0] d);
    cfg_wr_level = wl; cfg_wr_hyst = wh; cfg_wdata = wd;
    smp_valid = v; smp_data = d;
    @(negedge clk);
  endtask

  task automatic step_check(input string req, input logic v, input logic [7:0] d,
                            input logic ep, input logic ea);
    apply(1'b0, 1'b0, 8'h00, v, d);
    check(req, "trig_pulse", trig_pulse, ep);
    check(req, "armed", armed, ea);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    apply(1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
    apply(1'b0, 1'b0, 8'h00, 1'b0, 8'h00);
    check("R1", "armed after reset", armed, 1'b1);
    check("R1", "trig_pulse after reset", trig_pulse, 1'b0);
    rst_n = 1'b1;
  endtask

  initial begin
    @(negedge clk);
    do_reset();

    for (int i = 0; i < NV; i++) begin
      logic [20:0] v;
      v = VEC[i];
      apply(v[20], v[19], v[18:11], v[10], v[9:2]);
      check($sformatf("R2-R8 vector %0d", i), "trig_pulse", trig_pulse, v[1]);
      check($sformatf("vector %0d", i), "armed", armed, v[0]);
    end

    // R1: reset mid-run restores threshold 0x80 and hysteresis 4
    step_check("R2", 1'b1, 8'h05, 1'b0, 1'b0);
    do_reset();
    step_check("R1", 1'b1, 8'h80, 1'b0, 1'b1);
    step_check("R1", 1'b1, 8'h81, 1'b1, 1'b0);
    step_check("R1", 1'b1, 8'h7D, 1'b0, 1'b0);
    step_check("R1", 1'b1, 8'h7C, 1'b0, 1'b1);

    // R7: write in the same cycle as a qualifying sample, both strobes together
    apply(1'b1, 1'b1, 8'h40, 1'b1, 8'hFF);
    check("R7", "trig_pulse on write cycle", trig_pulse, 1'b0);
    check("R7", "armed after write", armed, 1'b1);
    step_check("R7", 1'b1, 8'h40, 1'b0, 1'b1);
    step_check("R7", 1'b1, 8'h41, 1'b1, 1'b0);
    // R6: hyst 0x40 equals level 0x40, bound is 0
    step_check("R6", 1'b1, 8'h01, 1'b0, 1'b0);
    // R7: write while disarmed re-arms
    apply(1'b0, 1'b1, 8'h40, 1'b0, 8'h00);
    check("R7", "armed after write while disarmed", armed, 1'b1);
    step_check("R7", 1'b0, 8'hFF, 1'b0, 1'b1);
    step_check("R3", 1'b1, 8'hFF, 1'b1, 1'b0);
    step_check("R3", 1'b0, 8'h00, 1'b0, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule